// File: doc/BRIEF.md
# Serial Register Programming Port

This block is the slave end of a three-wire control port: a serial clock, an active-low frame strobe and one data line. It gathers each frame, decodes its address and keeps the small set of control registers that the rest of the device uses. The registers hold the operating mode, the amplifier gain code and a sign-magnitude offset. A frame can also read a register back. For a read, the block drives the data line itself and raises an enable output so that the pad buffer outside the block can switch direction.

The three serial pins come into a two-stage synchronizer in the system clock domain. Their edges are detected there. A controller built as an enumerated state machine tracks the frame. Its states are `ST_IDLE` (strobe high, serial clock ignored), `ST_HEAD` (collecting the direction flag and the address), `ST_WDATA` (collecting write data), `ST_RDATA` (shifting read data out), `ST_WFULL` (exactly a full write frame received) and `ST_ABORT` (too many bits). Its transitions are: strobe fall from `ST_IDLE` to `ST_HEAD`. The fourth serial rise goes from `ST_HEAD` to `ST_WDATA` or `ST_RDATA`, depending on the flag. The thirteenth rise goes from `ST_WDATA` to `ST_WFULL`. Any further rise goes from `ST_WFULL` to `ST_ABORT`. A strobe rise returns any state to `ST_IDLE`, and when it leaves `ST_WFULL` it commits the write.

Top module: `ser_reg_if`

## Requirements
- R1: After reset: `cds_mode`=1, `clamp_hi`=1, `power_down`=0, `out_delay`=0, `single_byte`=0, `gain_code`=0, `ofs_sign`=0, `ofs_mag`=0, `ser_dout_oe`=0.
- R2: A frame is 13 bits, sampled on rising serial-clock edges while `ser_load_n` is low. The order is: direction flag (0 = write, 1 = read), then address bits 2..0, then data bits 8..0, most significant bit first.
- R3: A write takes effect on the rising edge of `ser_load_n` only if exactly 13 serial rises occurred in the frame. A frame with fewer rises changes nothing.
- R4: A frame with more than 13 serial rises changes nothing.
- R5: Writing address 000 sets `single_byte` from data bit 0, `out_delay` from bit 1, `power_down` from bit 2, `clamp_hi` from bit 3 and `cds_mode` from bit 4.
- R6: Writing address 010 sets `gain_code` from data bits 5..0. Bits 8..6 are ignored.
- R7: Writing address 101 sets `ofs_sign` from data bit 8 and `ofs_mag` from bits 7..0.
- R8: Writes to any address other than 000, 010 and 101 change no register.
- R9: In a read frame, `ser_dout_oe` rises after the falling serial edge that follows the fourth rise. From then on each falling edge presents the next data bit on `ser_dout`, D8 first. The enable stays high until `ser_load_n` rises and then returns low.
- R10: A read of any reserved address returns nine zeros.
- R11: Read-back of address 000 always shows bits 8..5 as 0,0,1,1. Read-back of address 010 always shows bits 8..6 as zero, whatever was written.
- R12: While `ser_load_n` is high, serial clock and data activity changes no register and `ser_dout_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial clock |
| ser_load_n | input | 1 | Frame strobe, low during a frame |
| ser_din | input | 1 | Serial data from the pad |
| ser_dout | output | 1 | Serial read data to the pad |
| ser_dout_oe | output | 1 | Pad drive enable for read data |
| cds_mode | output | 1 | 1 = double-sampling mode, 0 = sample-and-hold mode |
| clamp_hi | output | 1 | 1 = high clamp bias, 0 = low clamp bias |
| power_down | output | 1 | Power-down request |
| out_delay | output | 1 | Output delay enable |
| single_byte | output | 1 | Single-byte output mode |
| gain_code | output | 6 | Straight-binary gain code |
| ofs_sign | output | 1 | Offset sign (1 = negative) |
| ofs_mag | output | 8 | Offset magnitude |

## Verification
A controller that is in the wrong state shows up at the ports within one frame. A stuck header or data state either leaves the configuration outputs unchanged after a full write, or commits a short or long frame that should have been dropped. That is visible a few system clocks after the strobe rises. A bad read path or address latch puts a wrong bit on `ser_dout` in the first sampled data slot. An enable that fails to clear shows high right after the strobe returns. Every scenario therefore checks the register outputs after the frame, and reads the register back through the serial port.

// File: rtl/sri_pkg.sv
package sri_pkg;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 9;
    localparam int HDR_LEN   = 1 + ADDR_W;
    localparam int FRAME_LEN = HDR_LEN + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 2);
    localparam int CFG_W     = 5;
    localparam int GAIN_W    = 6;
    localparam int OFS_W     = DATA_W;

    localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'b000;
    localparam logic [ADDR_W-1:0] ADDR_GAIN = 3'b010;
    localparam logic [ADDR_W-1:0] ADDR_OFS  = 3'b101;

    localparam logic [DATA_W-CFG_W-1:0] CFG_FIXED = 4'b0011;
    localparam logic [CFG_W-1:0]        CFG_RST   = 5'b11000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_WDATA,
        ST_RDATA,
        ST_WFULL,
        ST_ABORT
    } sri_state_e;
endpackage

// File: rtl/sri_sync.sv
module sri_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sri_frame_fsm.sv
module sri_frame_fsm
    import sri_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              load_rise,
    input  logic              load_fall,
    input  logic              sdi,
    input  logic [DATA_W-1:0] rd_word,
    output sri_state_e        state_q,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              commit_we,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_LEN + 1);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_LEN - 1);
    localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(FRAME_LEN - 1);

    sri_state_e        state_d;
    logic              rw_q;
    logic [DATA_W-1:0] rd_sh;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load_fall) state_d = ST_HEAD;
            ST_HEAD:  if (sclk_rise && bit_cnt == HDR_LAST)
                          state_d = rw_q ? ST_RDATA : ST_WDATA;
            ST_WDATA: if (sclk_rise && bit_cnt == FRM_LAST) state_d = ST_WFULL;
            ST_WFULL: if (sclk_rise) state_d = ST_ABORT;
            ST_RDATA: state_d = ST_RDATA;
            ST_ABORT: state_d = ST_ABORT;
            default:  state_d = ST_IDLE;
        endcase
        if (load_rise) state_d = ST_IDLE;
    end

    assign commit_we = (state_q == ST_WFULL) && load_rise;

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rw_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rd_sh   <= '0;
            sdo     <= 1'b0;
            sdo_oe  <= 1'b0;
        end else begin
            if (load_fall) begin
                bit_cnt <= '0;
            end else if (sclk_rise && state_q != ST_IDLE && bit_cnt != CNT_MAX) begin
                bit_cnt <= bit_cnt + 1'b1;
            end

            if (sclk_rise && state_q == ST_HEAD) begin
                if (bit_cnt == '0) rw_q   <= sdi;
                else               addr_q <= {addr_q[ADDR_W-2:0], sdi};
            end
            if (sclk_rise && state_q == ST_WDATA)
                wdata_q <= {wdata_q[DATA_W-2:0], sdi};

            if (load_rise) begin
                sdo    <= 1'b0;
                sdo_oe <= 1'b0;
            end else if (sclk_fall && state_q == ST_RDATA) begin
                if (!sdo_oe) begin
                    sdo   <= rd_word[DATA_W-1];
                    rd_sh <= {rd_word[DATA_W-2:0], 1'b0};
                end else begin
                    sdo   <= rd_sh[DATA_W-1];
                    rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
                end
                sdo_oe <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sri_regfile.sv
module sri_regfile
    import sri_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [GAIN_W-1:0] gain_q,
    output logic [OFS_W-1:0]  ofs_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= CFG_RST;
            gain_q <= '0;
            ofs_q  <= '0;
        end else if (we) begin
            case (addr)
                ADDR_CFG:  cfg_q  <= wdata[CFG_W-1:0];
                ADDR_GAIN: gain_q <= wdata[GAIN_W-1:0];
                ADDR_OFS:  ofs_q  <= wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            ADDR_CFG:  rdata = {CFG_FIXED, cfg_q};
            ADDR_GAIN: rdata = {{(DATA_W-GAIN_W){1'b0}}, gain_q};
            ADDR_OFS:  rdata = ofs_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/ser_reg_if.sv
module ser_reg_if
    import sri_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_load_n,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              ser_dout_oe,
    output logic              cds_mode,
    output logic              clamp_hi,
    output logic              power_down,
    output logic              out_delay,
    output logic              single_byte,
    output logic [GAIN_W-1:0] gain_code,
    output logic              ofs_sign,
    output logic [OFS_W-2:0]  ofs_mag
);
    logic [2:0]        pins_s;
    logic              sclk_s, load_s, din_s;
    logic              sclk_p, load_p;
    logic              sclk_rise, sclk_fall, load_rise, load_fall;
    sri_state_e        state_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rd_word;
    logic              commit_we;
    logic [CFG_W-1:0]  cfg_q;
    logic [GAIN_W-1:0] gain_q;
    logic [OFS_W-1:0]  ofs_q;

    sri_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ser_din, ser_load_n, ser_clk}),
        .q(pins_s)
    );
    assign {din_s, load_s, sclk_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p <= 1'b0;
            load_p <= 1'b1;
        end else begin
            sclk_p <= sclk_s;
            load_p <= load_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_p;
    assign sclk_fall = ~sclk_s & sclk_p;
    assign load_rise = load_s & ~load_p;
    assign load_fall = ~load_s & load_p;

    sri_frame_fsm i_fsm (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .load_rise(load_rise), .load_fall(load_fall),
        .sdi(din_s), .rd_word(rd_word),
        .state_q(state_q), .bit_cnt(bit_cnt), .addr_q(addr_q),
        .wdata_q(wdata_q), .commit_we(commit_we),
        .sdo(ser_dout), .sdo_oe(ser_dout_oe)
    );

    sri_regfile i_regs (
        .clk(clk), .rst_n(rst_n),
        .we(commit_we), .addr(addr_q), .wdata(wdata_q), .rdata(rd_word),
        .cfg_q(cfg_q), .gain_q(gain_q), .ofs_q(ofs_q)
    );

    assign {cds_mode, clamp_hi, power_down, out_delay, single_byte} = cfg_q;
    assign gain_code = gain_q;
    assign ofs_sign  = ofs_q[OFS_W-1];
    assign ofs_mag   = ofs_q[OFS_W-2:0];
endmodule

// File: rtl/sri_checker.sv
module sri_checker
    import sri_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input sri_state_e        state_q,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              commit_we,
    input logic [ADDR_W-1:0] addr_q,
    input logic              oe,
    input logic [CFG_W+GAIN_W+OFS_W-1:0] regs
);
    logic reserved;
    assign reserved = addr_q != ADDR_CFG && addr_q != ADDR_GAIN && addr_q != ADDR_OFS;

    AST_COMMIT_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        commit_we |-> bit_cnt == CNT_W'(FRAME_LEN)); // R3
    AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_we |=> $stable(regs)); // R3
    AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_we && reserved) |=> $stable(regs)); // R8
    AST_OE_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> state_q == ST_RDATA); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> !oe); // R12
endmodule

bind ser_reg_if sri_checker i_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .bit_cnt(bit_cnt),
    .commit_we(commit_we), .addr_q(addr_q), .oe(ser_dout_oe),
    .regs({cfg_q, gain_q, ofs_q})
);

// File: tb/test_ser_reg_if.sv
module test_ser_reg_if;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 100;

    logic       clk = 0, rst_n = 0;
    logic       ser_clk = 0, ser_load_n = 1, ser_din = 0;
    logic       ser_dout, ser_dout_oe;
    logic       cds_mode, clamp_hi, power_down, out_delay, single_byte;
    logic [5:0] gain_code;
    logic       ofs_sign;
    logic [7:0] ofs_mag;

    int n_chk = 0, n_bad = 0;
    logic [4:0] e_cfg  = 5'b11000;
    logic [5:0] e_gain = 0;
    logic [8:0] e_ofs  = 0;
    logic [8:0] rd_cap, oe_cap;
    logic       pre_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_reg_if i_ser_reg_if (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_load_n(ser_load_n),
        .ser_din(ser_din), .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe),
        .cds_mode(cds_mode), .clamp_hi(clamp_hi), .power_down(power_down),
        .out_delay(out_delay), .single_byte(single_byte), .gain_code(gain_code),
        .ofs_sign(ofs_sign), .ofs_mag(ofs_mag)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_frame(input bit rw, input logic [2:0] a, input logic [8:0] d, input int nbits);
        logic [12:0] w;
        w = {rw, a, d};
        ser_load_n = 0;
        #HALF;
        for (int i = 0; i < nbits; i++) begin
            ser_din = (i < 13) ? w[12-i] : 1'b0;
            #HALF;
            if (i == 3) pre_oe = ser_dout_oe;
            if (i >= 4 && i < 13) begin
                rd_cap[12-i] = ser_dout;
                oe_cap[12-i] = ser_dout_oe;
            end
            ser_clk = 1;
            #HALF;
            ser_clk = 0;
        end
        #HALF;
        ser_load_n = 1;
        #(2*HALF);
    endtask

    task automatic check_outputs(input string req);
        check(req, {11'b0, cds_mode, clamp_hi, power_down, out_delay, single_byte}, {11'b0, e_cfg});
        check(req, {10'b0, gain_code}, {10'b0, e_gain});
        check(req, {7'b0, ofs_sign, ofs_mag}, {7'b0, e_ofs});
    endtask

    task automatic read_back(input string req, input logic [2:0] a, input logic [8:0] exp);
        do_frame(1'b1, a, 9'h0, 13);
        check(req, {7'b0, rd_cap}, {7'b0, exp});
        check({req, " R9 oe"}, {7'b0, oe_cap}, 16'h01FF);
        check({req, " R9 pre-oe"}, {15'b0, pre_oe}, 16'h0);
        check({req, " R9 oe-release"}, {15'b0, ser_dout_oe}, 16'h0);
    endtask

    task automatic t_reset;
        check("R1 oe", {15'b0, ser_dout_oe}, 16'h0);
        check_outputs("R1");
        read_back("R11 cfg default", 3'b000, 9'h078);
        read_back("R1 gain default", 3'b010, 9'h000);
    endtask

    task automatic t_cfg;
        do_frame(1'b0, 3'b000, 9'h1E5, 13);
        e_cfg = 5'b00101;
        check_outputs("R5 write 1E5");
        read_back("R11 cfg fixed", 3'b000, 9'h065);
        do_frame(1'b0, 3'b000, 9'h01A, 13);
        e_cfg = 5'b11010;
        check_outputs("R2 R5 write 01A");
        read_back("R5 cfg readback", 3'b000, 9'h07A);
    endtask

    task automatic t_gain;
        do_frame(1'b0, 3'b010, 9'h1FF, 13);
        e_gain = 6'h3F;
        check_outputs("R6 gain max");
        read_back("R11 gain fixed", 3'b010, 9'h03F);
        do_frame(1'b0, 3'b010, 9'h0C9, 13);
        e_gain = 6'h09;
        check_outputs("R6 gain 09");
    endtask

    task automatic t_offset;
        do_frame(1'b0, 3'b101, 9'h1A5, 13);
        e_ofs = 9'h1A5;
        check_outputs("R7 offset negative");
        read_back("R7 offset readback", 3'b101, 9'h1A5);
        do_frame(1'b0, 3'b101, 9'h07E, 13);
        e_ofs = 9'h07E;
        check_outputs("R7 offset positive");
    endtask

    task automatic t_short_long;
        do_frame(1'b0, 3'b000, 9'h01F, 12);
        check_outputs("R3 short frame");
        do_frame(1'b0, 3'b010, 9'h015, 14);
        check_outputs("R4 long frame");
        do_frame(1'b0, 3'b101, 9'h0FF, 16);
        check_outputs("R4 long frame 16");
    endtask

    task automatic t_reserved;
        do_frame(1'b0, 3'b001, 9'h1FF, 13);
        do_frame(1'b0, 3'b111, 9'h000, 13);
        do_frame(1'b0, 3'b100, 9'h0AA, 13);
        check_outputs("R8 reserved writes");
        read_back("R10 reserved 011", 3'b011, 9'h000);
        read_back("R10 reserved 110", 3'b110, 9'h000);
    endtask

    task automatic t_idle_clock;
        logic seen_oe;
        seen_oe = 0;
        for (int i = 0; i < 20; i++) begin
            ser_din = i[0];
            #HALF;
            seen_oe |= ser_dout_oe;
            ser_clk = 1;
            #HALF;
            seen_oe |= ser_dout_oe;
            ser_clk = 0;
        end
        #(2*HALF);
        check("R12 oe idle", {15'b0, seen_oe}, 16'h0);
        check_outputs("R12 idle clocks");
        read_back("R12 cfg after idle", 3'b000, {4'b0011, e_cfg});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(3*CLK_PERIOD + 3);
        rst_n = 1;
        #(5*CLK_PERIOD);
        t_reset;
        t_cfg;
        t_gain;
        t_offset;
        t_short_long;
        t_reserved;
        t_idle_clock;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule